// File: doc/BRIEF.md
# Programmable Panel Timing Generator

This block produces the raster timing for an active-matrix display panel: a divided pixel clock, horizontal and vertical sync, a data-enable strobe, the coordinates of the pixel currently being shown, and single-cycle start-of-frame and end-of-frame pulses. Every interval comes from two packed 32-bit geometry words, one for the horizontal axis and one for the vertical axis. A third control word holds the pixel clock divisor, a double-rate clock mode and four polarity selects.

All three words are captured on every system clock while `enable` is low. They are frozen while `enable` is high, so software programs the words, raises `enable`, and the raster runs from the top-left corner of the sync interval. Each line runs sync, then leading wait, then active pixels, then trailing wait. Each frame follows the same order, counted in lines. Lowering `enable` stops the raster and parks every output at its inactive level.

Top module: `lcdtg_top`

## Requirements
- R1: While disabled (and from reset), hSync, vSync and dataEn sit at their inactive levels, pixClk sits at its idle level (raw clock low, then the polarity of R3 applied), pixX and lineY are 0, and sof and eof are 0. Configuration inputs are captured each clock while disabled.
- R2: The pixel period P is 2*(ctlCfg[7:0]+1) system clocks, or ctlCfg[7:0]+1 when ctlCfg[27] is 1. Counting system clocks from 0 in each period, the raw pixel clock is low for the first floor(P/2) clocks and high for the rest. The raster position advances once per period.
- R3: pixClk equals the raw clock when ctlCfg[22] is 1, so data changes on its falling edge. When ctlCfg[22] is 0, pixClk is the inverse of the raw clock, so data changes on its rising edge.
- R4: A line is made of four intervals. Sync lasts hCfg[15:10]+1 pixels. The leading wait lasts hCfg[31:24]+1 pixels. The active part lasts hCfg[9:0]+1 pixels. The trailing wait lasts hCfg[23:16]+1 pixels.
- R5: A frame is made of four intervals, counted in lines. Sync lasts vCfg[15:10]+1 lines. The leading wait lasts vCfg[31:24] lines, and the trailing wait lasts vCfg[23:16] lines; 0 means no wait lines. The active part lasts vCfg[9:0]+1 lines.
- R6: hSync is high during horizontal sync when ctlCfg[21] is 0, and low during it when ctlCfg[21] is 1. vSync follows the same rule with ctlCfg[20].
- R7: dataEn is asserted only when both axes are inside their active parts. It is active high when ctlCfg[23] is 0 and active low when ctlCfg[23] is 1.
- R8: Inside the active window, pixX and lineY give the zero-based offsets of the current pixel and line from the first active pixel. Outside the active window both read 0.
- R9: sof is high for exactly one system clock: the first clock of the first active pixel of the first active line.
- R10: eof is high for exactly one system clock: the first clock of the pixel period that follows the last active pixel of the last active line.
- R11: Changes on hCfg, vCfg and ctlCfg while enabled have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the raster when high; captures configuration when low |
| hCfg | input | 32 | Horizontal geometry word |
| vCfg | input | 32 | Vertical geometry word |
| ctlCfg | input | 32 | Divisor, double-rate mode and polarity word |
| pixClk | output | 1 | Divided pixel clock with selectable polarity |
| hSync | output | 1 | Horizontal sync |
| vSync | output | 1 | Vertical sync |
| dataEn | output | 1 | Data enable with selectable polarity |
| pixX | output | 10 | Active pixel offset within the line |
| lineY | output | 10 | Active line offset within the frame |
| sof | output | 1 | Start-of-frame pulse |
| eof | output | 1 | End-of-frame pulse |

## Verification
The clock edge that first samples `enable` high arms the raster. From that edge on, the outputs at system clock t (t = 0 in the following low phase) are a pure function of t: the divider phase is t mod P, and the pixel index is t / P, split into column and line with the line and frame totals. All outputs are decoded from registers with no further pipeline, so each one is due in the same cycle as the state it reflects. The bench counts t itself and compares every output at each falling edge against that arithmetic. After a disable, two full clocks pass before the idle levels are checked, so the newly captured polarities have settled.

// File: rtl/lcdtg_pkg.sv
package lcdtg_pkg;
  // strobes from the divider control to the raster datapath
  typedef struct packed {
    logic run;    // raster is running
    logic tick;   // last system clock of a pixel period
    logic phase0; // first system clock of a pixel period
  } tgStrobe_t;
endpackage

// File: rtl/lcdtg_ctrl.sv
module lcdtg_ctrl
  import lcdtg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic [31:0] ctlCfg,
  output tgStrobe_t   strobe,
  output logic        pixClkRaw,
  output logic [31:0] ctlQ
);
  localparam int CNT_W = DIV_W + 2;

  logic             running;
  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] half;

  always_comb begin
    if (ctlQ[27]) period = CNT_W'(ctlQ[DIV_W-1:0]) + CNT_W'(1);
    else          period = (CNT_W'(ctlQ[DIV_W-1:0]) + CNT_W'(1)) << 1;
    half = period >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctlQ    <= '0;
      running <= 1'b0;
      divCnt  <= '0;
    end else if (!enable) begin
      ctlQ    <= ctlCfg;
      running <= 1'b0;
      divCnt  <= '0;
    end else if (!running) begin
      running <= 1'b1;
    end else if (divCnt == period - CNT_W'(1)) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + CNT_W'(1);
    end
  end

  always_comb begin
    strobe.run    = running;
    strobe.tick   = running && (divCnt == period - CNT_W'(1));
    strobe.phase0 = running && (divCnt == '0);
    pixClkRaw     = running && (divCnt >= half);
  end

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (divCnt < period)); // R2
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (running && enable) |=> $stable(ctlQ)); // R11
endmodule

// File: rtl/lcdtg_dp.sv
module lcdtg_dp
  import lcdtg_pkg::*;
#(
  parameter int POS_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic [31:0] hCfg,
  input  logic [31:0] vCfg,
  input  tgStrobe_t   strobe,
  output logic        hSyncAct,
  output logic        vSyncAct,
  output logic        deAct,
  output logic [9:0]  pixX,
  output logic [9:0]  lineY,
  output logic        sof,
  output logic        eof
);
  localparam logic [POS_W-1:0] ONE = POS_W'(1);

  logic [31:0]      hQ, vQ;
  logic [POS_W-1:0] hPos, vPos;
  logic [POS_W-1:0] hSw, hStart, hEnd, hTotal;
  logic [POS_W-1:0] vSw, vStart, vEnd, vTotal;
  logic             hIn, vIn;

  always_comb begin
    hSw    = POS_W'(hQ[15:10]) + ONE;
    hStart = hSw + POS_W'(hQ[31:24]) + ONE;
    hEnd   = hStart + POS_W'(hQ[9:0]) + ONE;
    hTotal = hEnd + POS_W'(hQ[23:16]) + ONE;
    vSw    = POS_W'(vQ[15:10]) + ONE;
    vStart = vSw + POS_W'(vQ[31:24]);
    vEnd   = vStart + POS_W'(vQ[9:0]) + ONE;
    vTotal = vEnd + POS_W'(vQ[23:16]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hQ <= '0;
      vQ <= '0;
    end else if (!enable) begin
      hQ <= hCfg;
      vQ <= vCfg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hPos <= '0;
      vPos <= '0;
    end else if (!strobe.run) begin
      hPos <= '0;
      vPos <= '0;
    end else if (strobe.tick) begin
      if (hPos == hTotal - ONE) begin
        hPos <= '0;
        vPos <= (vPos == vTotal - ONE) ? '0 : vPos + ONE;
      end else begin
        hPos <= hPos + ONE;
      end
    end
  end

  always_comb begin
    hIn      = (hPos >= hStart) && (hPos < hEnd);
    vIn      = (vPos >= vStart) && (vPos < vEnd);
    hSyncAct = strobe.run && (hPos < hSw);
    vSyncAct = strobe.run && (vPos < vSw);
    deAct    = strobe.run && hIn && vIn;
    pixX     = deAct ? 10'(hPos - hStart) : 10'd0;
    lineY    = deAct ? 10'(vPos - vStart) : 10'd0;
    sof      = strobe.phase0 && (hPos == hStart) && (vPos == vStart);
    eof      = strobe.phase0 && (hPos == hEnd) && (vPos == vEnd - ONE);
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.run |-> (!hSyncAct && !vSyncAct && !deAct && !sof && !eof)); // R1
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.run && !strobe.tick) |=> ($stable(hPos) && $stable(vPos))); // R2
  AST_HPOS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.run |-> (hPos < hTotal)); // R4
  AST_VPOS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.run |-> (vPos < vTotal)); // R5
  AST_SOF_IN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> (deAct && pixX == 10'd0 && lineY == 10'd0)); // R9
  AST_EOF_AFTER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    eof |-> ($past(deAct) && !deAct)); // R10
endmodule

// File: rtl/lcdtg_top.sv
module lcdtg_top
  import lcdtg_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int POS_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic [31:0] hCfg,
  input  logic [31:0] vCfg,
  input  logic [31:0] ctlCfg,
  output logic        pixClk,
  output logic        hSync,
  output logic        vSync,
  output logic        dataEn,
  output logic [9:0]  pixX,
  output logic [9:0]  lineY,
  output logic        sof,
  output logic        eof
);
  tgStrobe_t   strobe;
  logic        pixClkRaw;
  logic [31:0] ctlQ;
  logic        hSyncAct, vSyncAct, deAct;

  lcdtg_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ctlCfg(ctlCfg),
    .strobe(strobe), .pixClkRaw(pixClkRaw), .ctlQ(ctlQ)
  );

  lcdtg_dp #(.POS_W(POS_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .enable(enable), .hCfg(hCfg), .vCfg(vCfg),
    .strobe(strobe), .hSyncAct(hSyncAct), .vSyncAct(vSyncAct), .deAct(deAct),
    .pixX(pixX), .lineY(lineY), .sof(sof), .eof(eof)
  );

  always_comb begin
    pixClk = ctlQ[22] ? pixClkRaw : ~pixClkRaw;
    hSync  = hSyncAct ^ ctlQ[21];
    vSync  = vSyncAct ^ ctlQ[20];
    dataEn = deAct ^ ctlQ[23];
  end
endmodule

// File: tb/tb_lcdtg_top.sv
module tb_lcdtg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [31:0] hCfg = '0, vCfg = '0, ctlCfg = '0;
  logic        pixClk, hSync, vSync, dataEn, sof, eof;
  logic [9:0]  pixX, lineY;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  lcdtg_top dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .hCfg(hCfg), .vCfg(vCfg),
    .ctlCfg(ctlCfg), .pixClk(pixClk), .hSync(hSync), .vSync(vSync),
    .dataEn(dataEn), .pixX(pixX), .lineY(lineY), .sof(sof), .eof(eof)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish, act=%0d exp=<190000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // geometry sets: {hsw, blw, ppl, elw, vsw, bfw, lpp, efw} as field values
  function automatic int geo(input int g, input int f);
    int t[4][8] = '{'{0,0,1,0, 0,0,1,0},
                    '{1,2,2,1, 1,1,2,2},
                    '{0,1,0,2, 0,2,0,1},
                    '{2,0,3,0, 2,0,1,0}};
    return t[g][f];
  endfunction

  task automatic checkIdle(input int pol, input string tag);
    chk(tag, "hSync idle", int'(hSync), (pol >> 1) & 1);
    chk(tag, "vSync idle", int'(vSync), pol & 1);
    chk(tag, "dataEn idle", int'(dataEn), (pol >> 3) & 1);
    chk(tag, "pixClk idle", int'(pixClk), ((pol >> 2) & 1) ? 0 : 1);
    chk(tag, "pixX idle", int'(pixX), 0);
    chk(tag, "lineY idle", int'(lineY), 0);
    chk(tag, "sof idle", int'(sof), 0);
    chk(tag, "eof idle", int'(eof), 0);
  endtask

  task automatic runCfg(input int g, input int dv, input int dbl, input int pol);
    int hsw = geo(g,0), blw = geo(g,1), ppl = geo(g,2), elw = geo(g,3);
    int vsw = geo(g,4), bfw = geo(g,5), lpp = geo(g,6), efw = geo(g,7);
    int P  = dbl ? dv + 1 : 2 * (dv + 1);
    int hS = hsw + 1 + blw + 1;
    int hE = hS + ppl + 1;
    int hT = hE + elw + 1;
    int vS = vsw + 1 + bfw;
    int vE = vS + lpp + 1;
    int vT = vE + efw;
    int n  = P * hT * vT * 2 + 3;
    @(negedge clk);
    enable = 1'b0;
    hCfg   = (blw << 24) | (elw << 16) | (hsw << 10) | ppl;
    vCfg   = (bfw << 24) | (efw << 16) | (vsw << 10) | lpp;
    ctlCfg = (dbl << 27) | (pol << 20) | dv;
    @(negedge clk);
    @(negedge clk);
    checkIdle(pol, "R1");
    enable = 1'b1;
    @(posedge clk);
    for (int t = 0; t < n; t++) begin
      int ph, k, h, v, raw, act, eDe;
      @(negedge clk);
      ph  = t % P;
      k   = t / P;
      h   = k % hT;
      v   = (k / hT) % vT;
      raw = (ph >= P / 2) ? 1 : 0;
      act = (h >= hS && h < hE && v >= vS && v < vE) ? 1 : 0;
      eDe = act ^ ((pol >> 3) & 1);
      chk("R2_R3", "pixClk", int'(pixClk), ((pol >> 2) & 1) ? raw : 1 - raw);
      chk("R4_R6", "hSync", int'(hSync), ((h < hsw + 1) ? 1 : 0) ^ ((pol >> 1) & 1));
      chk("R5_R6", "vSync", int'(vSync), ((v < vsw + 1) ? 1 : 0) ^ (pol & 1));
      chk("R7", "dataEn", int'(dataEn), eDe);
      chk("R8", "pixX", int'(pixX), act ? h - hS : 0);
      chk("R8", "lineY", int'(lineY), act ? v - vS : 0);
      chk("R9", "sof", int'(sof), (ph == 0 && h == hS && v == vS) ? 1 : 0);
      chk("R10", "eof", int'(eof), (ph == 0 && h == hE && v == vE - 1) ? 1 : 0);
      if (t == n / 2) begin
        // R11: scramble every configuration word mid-run
        hCfg   = ~hCfg;
        vCfg   = 32'h0155_5aa5;
        ctlCfg = ~ctlCfg;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkIdle(0, "R1");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    checkIdle(0, "R1");
    for (int g = 0; g < 4; g++)
      for (int dv = 0; dv < 3; dv++)
        for (int dbl = 0; dbl < 2; dbl++)
          runCfg(g, dv, dbl, (g * 6 + dv * 2 + dbl) & 15);
    @(negedge clk);
    enable = 1'b0;
    ctlCfg = 32'h00a0_0000;
    repeat (2) @(negedge clk);
    checkIdle(10, "R1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule